// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block sits between issue and the architectural state of a speculative out-of-order core. Each issued instruction claims one slot at the tail of a circular buffer. The slot number goes back to the issuer and becomes the destination tag for that instruction. Execution units later broadcast results on a shared result bus, tagged with that slot number. The buffer stores each result in its slot, whatever order the results arrive in.

The oldest slot, at the head, retires as soon as its result is present. A register-kind slot updates the register file, a store-kind slot drives the store port, and a correctly predicted branch simply leaves. At most one slot retires per cycle.

When the head holds a branch marked as mispredicted, the whole buffer is discarded. A flush pulse then tells the external reservation stations to drop their work. A head slot marked with a fault is handled the same way and also reports its tag on a fault output. The architectural state therefore only ever reflects instructions that come before the faulting or mispredicted one.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `alloc_tag` is 0 and all write, flush and fault outputs are 0.
- R2: Each accepted issue request receives the current tail slot as its tag; successive tags count up by one and wrap from DEPTH-1 to 0.
- R3: With DEPTH live slots `alloc_ready` is 0, and an issue request made while full is dropped without moving the tail.
- R4: A broadcast result is stored in the slot named by `res_tag`; a completed slot that is not at the head produces no architectural write.
- R5: Slots retire strictly from the head, one per cycle at most, and only once their result is present; the write appears in the cycle after the edge at which the completed slot is at the head.
- R6: Slot kind encoding is 0 = register, 1 = store, 2 = branch. Register retirement pulses `rf_we` with `rf_idx` = destination and `rf_data` = result; store retirement pulses `st_we` with `st_addr` = destination and `st_data` = result; branch retirement writes nothing.
- R7: A head slot of kind 2 whose result carried the mispredict flag raises `flush` for exactly one cycle, discards every slot without any write, and leaves the buffer empty with the next tag 0.
- R8: A head slot whose result carried the fault flag raises `fault` with `fault_tag` equal to that slot, performs no write, and flushes the buffer as in R7.
- R9: An issue request presented in the cycle in which a flush is decided is discarded.
- R10: Retiring a slot frees it, so `alloc_ready` returns to 1 once the buffer drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Issue request |
| alloc_kind | input | 2 | Kind of issued instruction (0 reg, 1 store, 2 branch) |
| alloc_dest | input | AREG_W | Destination register, or store address |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | TAG_W | Slot given to the current request |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_data | input | DATA_W | Result value |
| res_mispred | input | 1 | Branch outcome was mispredicted |
| res_fault | input | 1 | Instruction raised a fault |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | AREG_W | Register file write index |
| rf_data | output | DATA_W | Register file write data |
| st_we | output | 1 | Store port strobe |
| st_addr | output | AREG_W | Store address field |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | One-cycle pulse: all slots discarded |
| fault | output | 1 | One-cycle pulse: head slot faulted |
| fault_tag | output | TAG_W | Slot that faulted |

## Verification
The assertions rely on a contract with the result bus. A result is only broadcast for a slot that is live, and only once per slot. A result never arrives in the same cycle as a flush for a slot being discarded.

The stimulus keeps to this contract. It tracks the tags handed out at issue and broadcasts each one exactly once. It also issues nothing while a discarded slot could still be targeted. The one exception is the deliberate issue attempt in the flush cycle, which carries no result.

Sweeps cover a full buffer, reverse-order completion, tag wrap-around, a mispredict flush, and a fault behind a retired slot.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rq_ring.sv
module rq_ring #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop)  head <= step(head);
      if (push) tail <= step(tail);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // R3: occupancy bound and no push into a full ring
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r3_push_when_room: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R5: nothing retires from an empty ring
  a_r5_pop_needs_entry: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rq_slots.sv
module rq_slots
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  kind_e             wr_kind,
  input  logic [AREG_W-1:0] wr_dest,
  input  logic              res_en,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_mispred,
  input  logic              res_fault,
  input  logic              rel_en,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_live,
  output logic              rd_done,
  output kind_e             rd_kind,
  output logic [AREG_W-1:0] rd_dest,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mispred,
  output logic              rd_fault
);
  typedef struct packed {
    kind_e             kind;
    logic [AREG_W-1:0] dest;
  } meta_t;

  meta_t             meta_mem [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic [DEPTH-1:0]  live, done, mis, flt;

  // storage without reset, one write port each, so it maps onto memory
  always_ff @(posedge clk) begin
    if (wr_en) meta_mem[wr_tag] <= '{kind: wr_kind, dest: wr_dest};
  end

  always_ff @(posedge clk) begin
    if (res_en) val_mem[res_tag] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      live <= '0;
    end else begin
      if (rel_en) live[rd_tag] <= 1'b0;
      if (wr_en)  live[wr_tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= '0;
      mis  <= '0;
      flt  <= '0;
    end else begin
      if (wr_en) begin
        done[wr_tag] <= 1'b0;
        mis[wr_tag]  <= 1'b0;
        flt[wr_tag]  <= 1'b0;
      end
      if (res_en) begin
        done[res_tag] <= 1'b1;
        mis[res_tag]  <= res_mispred;
        flt[res_tag]  <= res_fault;
      end
    end
  end

  assign rd_live    = live[rd_tag];
  assign rd_done    = done[rd_tag];
  assign rd_kind    = meta_mem[rd_tag].kind;
  assign rd_dest    = meta_mem[rd_tag].dest;
  assign rd_data    = val_mem[rd_tag];
  assign rd_mispred = mis[rd_tag];
  assign rd_fault   = flt[rd_tag];

  // R4: results only target live, not yet completed slots
  a_r4_result_to_live: assert property (@(posedge clk) disable iff (rst)
    res_en |-> live[res_tag]);
  a_r4_single_result: assert property (@(posedge clk) disable iff (rst)
    res_en |-> !done[res_tag]);
  // R2: a new slot is never handed out while still live
  a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !live[wr_tag]);
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic [1:0]        alloc_kind,
  input  logic [AREG_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_mispred,
  input  logic              res_fault,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_we,
  output logic [AREG_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic              fault,
  output logic [TAG_W-1:0]  fault_tag
);
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, empty;
  logic              push, retire, kill, head_ok;
  logic              h_live, h_done, h_mis, h_flt;
  kind_e             h_kind;
  logic [AREG_W-1:0] h_dest;
  logic [DATA_W-1:0] h_data;

  assign head_ok = !empty && h_live && h_done;
  assign kill    = head_ok && (h_flt || (h_kind == KIND_BRANCH && h_mis));
  assign retire  = head_ok && !kill;
  assign push    = alloc_req && !full && !kill;

  rq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (retire),
    .clear (kill),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rq_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .clear       (kill),
    .wr_en       (push),
    .wr_tag      (tail),
    .wr_kind     (kind_e'(alloc_kind)),
    .wr_dest     (alloc_dest),
    .res_en      (res_valid),
    .res_tag     (res_tag),
    .res_data    (res_data),
    .res_mispred (res_mispred),
    .res_fault   (res_fault),
    .rel_en      (retire),
    .rd_tag      (head),
    .rd_live     (h_live),
    .rd_done     (h_done),
    .rd_kind     (h_kind),
    .rd_dest     (h_dest),
    .rd_data     (h_data),
    .rd_mispred  (h_mis),
    .rd_fault    (h_flt)
  );

  assign alloc_ready = !full;
  assign alloc_tag   = tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we     <= 1'b0;
      rf_idx    <= '0;
      rf_data   <= '0;
      st_we     <= 1'b0;
      st_addr   <= '0;
      st_data   <= '0;
      flush     <= 1'b0;
      fault     <= 1'b0;
      fault_tag <= '0;
    end else begin
      rf_we <= retire && (h_kind == KIND_REG);
      st_we <= retire && (h_kind == KIND_STORE);
      if (retire) begin
        rf_idx  <= h_dest;
        rf_data <= h_data;
        st_addr <= h_dest;
        st_data <= h_data;
      end
      flush <= kill;
      fault <= head_ok && h_flt;
      if (head_ok && h_flt) fault_tag <= head;
    end
  end

  // R7: flush is a single-cycle pulse and leaves the buffer empty
  a_r7_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |-> (count == '0 && alloc_tag == '0));
  // R6: a single retirement never drives both write ports
  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && st_we));
  // R8: a fault is always accompanied by a flush, never by a write
  a_r8_fault_flushes: assert property (@(posedge clk) disable iff (rst)
    fault |-> (flush && !rf_we && !st_we));
  // R7: discarded slots produce no write
  a_r7_no_write_on_flush: assert property (@(posedge clk) disable iff (rst)
    flush |-> !(rf_we || st_we));
endmodule

// File: tb/retire_queue_bench.sv
module retire_queue_bench;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int TW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic [1:0]    alloc_kind = '0;
  logic [AW-1:0] alloc_dest = '0;
  logic          alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic          res_valid = 1'b0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic          res_mispred = 1'b0;
  logic          res_fault = 1'b0;
  logic          rf_we, st_we, flush, fault;
  logic [AW-1:0] rf_idx, st_addr;
  logic [DW-1:0] rf_data, st_data;
  logic [TW-1:0] fault_tag;

  always #4 clk = ~clk;

  retire_queue #(.DEPTH(DEPTH), .DATA_W(DW), .AREG_W(AW)) u_retire_queue (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .res_mispred(res_mispred), .res_fault(res_fault),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .flush(flush), .fault(fault), .fault_tag(fault_tag)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int rn = 0, sn = 0, fln = 0, ftn = 0;
  logic [AW-1:0] r_idx [32];
  logic [DW-1:0] r_dat [32];
  int            r_cyc [32];
  logic [AW-1:0] s_adr [32];
  logic [DW-1:0] s_dat [32];
  logic [TW-1:0] last_ftag;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we) begin r_idx[rn] = rf_idx; r_dat[rn] = rf_data; r_cyc[rn] = cyc; rn++; end
      if (st_we) begin s_adr[sn] = st_addr; s_dat[sn] = st_data; sn++; end
      if (flush) fln++;
      if (fault) begin ftn++; last_ftag = fault_tag; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] d, output logic [TW-1:0] t);
    chk("R2 slot free at issue", 32'(alloc_ready), 32'd1);
    alloc_req = 1'b1; alloc_kind = k; alloc_dest = d; t = alloc_tag;
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic try_alloc();
    alloc_req = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd31;
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic result(input logic [TW-1:0] t, input logic [DW-1:0] v,
                        input logic m, input logic f);
    res_valid = 1'b1; res_tag = t; res_data = v; res_mispred = m; res_fault = f;
    @(negedge clk);
    res_valid = 1'b0; res_mispred = 1'b0; res_fault = 1'b0;
  endtask

  function automatic logic [DW-1:0] val_of(input int i);
    return 32'h1000 + 32'(i) * 32'd17;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] t;
    int base_r, base_s, base_f;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1 alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1 quiet outputs", 32'({rf_we, st_we, flush, fault}), 32'd0);

    // R2/R3 fill with kinds i%3, dest i+3
    for (int i = 0; i < DEPTH; i++) begin
      issue(2'(i % 3), 5'(i + 3), t);
      chk("R2 tag sequence", 32'(t), 32'(i));
    end
    chk("R3 full blocks issue", 32'(alloc_ready), 32'd0);
    try_alloc();
    chk("R3 request when full dropped", 32'(alloc_tag), 32'd0);
    // R4 complete out of order, head last
    for (int i = DEPTH - 1; i >= 1; i--) result(3'(i), val_of(i), 1'b0, 1'b0);
    idle(3);
    chk("R4 no retire without head", 32'(rn + sn), 32'd0);
    result(3'd0, val_of(0), 1'b0, 1'b0);
    idle(12);
    // R5/R6 in-order retirement by kind
    chk("R6 register writes", 32'(rn), 32'd3);
    chk("R6 store writes", 32'(sn), 32'd3);
    for (int j = 0; j < 3; j++) begin
      chk("R5 reg order idx", 32'(r_idx[j]), 32'(3 * j + 3));
      chk("R6 reg data", r_dat[j], val_of(3 * j));
      chk("R6 store addr", 32'(s_adr[j]), 32'(3 * j + 4));
      chk("R6 store data", s_dat[j], val_of(3 * j + 1));
    end
    chk("R5 one per cycle spacing", 32'(r_cyc[1] - r_cyc[0]), 32'd3);
    chk("R5 one per cycle spacing", 32'(r_cyc[2] - r_cyc[1]), 32'd3);
    chk("R10 slots freed", 32'(alloc_ready), 32'd1);
    chk("R3 tail unchanged by dropped request", 32'(alloc_tag), 32'd0);

    // R2 wrap-around
    base_r = rn;
    for (int i = 0; i < 5; i++) begin
      issue(2'd0, 5'(i), t);
      result(t, val_of(40 + i), 1'b0, 1'b0);
    end
    idle(4);
    for (int i = 0; i < 6; i++) begin
      issue(2'd0, 5'(10 + i), t);
      chk("R2 wrapped tag", 32'(t), 32'((5 + i) % DEPTH));
    end
    for (int i = 5; i >= 0; i--) result(3'((5 + i) % DEPTH), val_of(60 + i), 1'b0, 1'b0);
    idle(10);
    chk("R5 wrap retire count", 32'(rn - base_r), 32'd11);
    for (int i = 0; i < 6; i++) begin
      chk("R5 wrap order idx", 32'(r_idx[base_r + 5 + i]), 32'(10 + i));
      chk("R5 wrap order data", r_dat[base_r + 5 + i], val_of(60 + i));
    end

    // R7/R9 mispredicted branch at head, issue in flush cycle
    base_r = rn; base_s = sn; base_f = fln;
    issue(2'd2, 5'd0, t);
    chk("R2 tag after wrap", 32'(t), 32'd3);
    issue(2'd0, 5'd20, t);
    issue(2'd1, 5'd21, t);
    result(3'd4, 32'hAAAA, 1'b0, 1'b0);
    result(3'd5, 32'hBBBB, 1'b0, 1'b0);
    result(3'd3, 32'h0, 1'b1, 1'b0);
    try_alloc();
    idle(4);
    chk("R7 one flush cycle", 32'(fln - base_f), 32'd1);
    chk("R7 no writes from discarded", 32'((rn - base_r) + (sn - base_s)), 32'd0);
    chk("R9 issue in flush cycle dropped", 32'(alloc_tag), 32'd0);
    chk("R7 buffer empty", 32'(alloc_ready), 32'd1);

    // R8 fault behind a retired slot
    base_r = rn; base_f = fln;
    issue(2'd0, 5'd7, t);
    issue(2'd0, 5'd8, t);
    issue(2'd0, 5'd9, t);
    result(3'd1, 32'hDEAD, 1'b0, 1'b1);
    result(3'd2, 32'hCCCC, 1'b0, 1'b0);
    result(3'd0, 32'h1234, 1'b0, 1'b0);
    idle(6);
    chk("R8 only older slot retired", 32'(rn - base_r), 32'd1);
    chk("R8 older slot data", r_dat[base_r], 32'h1234);
    chk("R8 fault pulses", 32'(ftn), 32'd1);
    chk("R8 fault tag", 32'(last_ftag), 32'd1);
    chk("R8 flush with fault", 32'(fln - base_f), 32'd1);
    chk("R8 buffer empty", 32'(alloc_tag), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule